// File: doc/BRIEF.md
# Shadowed Special-Register Address Window

This block sits between a small processor core and its 512-word register-file memory. One contiguous window of word addresses can show either the RAM words at those addresses or a set of special-function registers. A single shadow-enable bit chooses which one data operands see. Operand reads and writes obey that bit. Instruction fetches ignore it and always read RAM, so code can be stored underneath the register window and still execute while the registers are exposed.

Because a window register is reached through the normal operand port, the core's ordinary move, add and subtract operations work on registers directly: a read-modify-write reads the register, and the result is written back to the same address. The last slot of the window holds a bank selector that is always visible, whatever the shadow bit is. It chooses which group of registers fills the remaining slots. A write that stores a call's return address is flagged by the core. Such a write always lands in RAM, even inside the window. A parameter fixed at build time places the window at the bottom or at the top of the address space.

Top module: `shadow_window`

## Requirements
- R1: After reset the shadow bit is clear, the bank selector reads 0 and every special register reads 0 once exposed.
- R2: With the shadow bit clear, operand reads and writes at window slots other than the bank slot reach RAM, and the special registers keep their values.
- R3: With the shadow bit set, an operand read at window slot s (s below WIN_SIZE-1) returns register s of the selected bank. An operand write there updates only that register, and the RAM word keeps its old value.
- R4: The fetch port always returns the RAM word at the fetch address, whatever the shadow bit and the bank selector are.
- R5: Operand accesses at addresses outside the window always reach RAM.
- R6: A control write (ctl_we high) loads ctl_shadow into the shadow bit at the clock edge. Operand accesses in the same cycle use the old value, and accesses from the next cycle on use the new one.
- R7: A write with op_call high always updates RAM, even inside the window and even at the bank slot. It updates neither a register nor the bank selector.
- R8: Window slot WIN_SIZE-1 is the bank selector whatever the shadow bit is. A non-call write there loads op_wdata[BANK_W-1:0] (BANK_W = log2 NUM_BANKS, 2 by default) into the selector. A read there returns the selector zero-extended. The RAM word under this slot changes only through call writes.
- R9: Each bank holds its own WIN_SIZE-1 registers. Changing the bank selector changes which registers appear, and the registers of the other banks keep their values.
- R10: With WIN_AT_TOP=0 the window covers addresses 0 to WIN_SIZE-1. With WIN_AT_TOP=1 it covers the last WIN_SIZE addresses (496 to 511 by default). Every rule above applies to the window wherever it sits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Instruction fetch word address |
| fetch_data | output | DATA_W | RAM word at fetch_addr |
| op_raddr | input | ADDR_W | Operand read address |
| op_rdata | output | DATA_W | Operand read data (RAM, register or bank selector) |
| op_we | input | 1 | Operand write strobe |
| op_call | input | 1 | Marks the write as a return-address store; forces RAM |
| op_waddr | input | ADDR_W | Operand write address |
| op_wdata | input | DATA_W | Operand write data |
| ctl_we | input | 1 | Control write strobe for the shadow bit |
| ctl_shadow | input | 1 | New shadow bit value |

## Verification
Two copies run side by side, one with the window at the bottom and one with it at the top, and both get the same stimulus. The bench sweeps every address through the fetch and operand ports after each phase of the test. The phases are a RAM fill made only of call writes, then reads with the shadow bit clear, then with it set, then with each bank selected in turn. The same address is therefore read under different modes, which separates RAM contents from register contents and one bank from another. The same addresses fall inside one copy's window and outside the other's, so the bench can tell whether the window boundaries are placed correctly. Targeted steps combine a control write with an operand write or read in the same cycle, to confirm that the shadow bit changes one cycle later. They also issue call writes into the window and write a bank value with its upper bits set.

// File: rtl/shadow_win_pkg.sv
package shadow_win_pkg;

  typedef enum logic [1:0] {
    ROUTE_RAM  = 2'd0,
    ROUTE_SFR  = 2'd1,
    ROUTE_BANK = 2'd2
  } route_e;

  // Decide where an operand access lands.
  function automatic route_e route_access(input logic in_win,
                                          input logic bank_slot,
                                          input logic shadow_on,
                                          input logic force_ram);
    route_e r;
    if (force_ram || !in_win) begin
      r = ROUTE_RAM;
    end else if (bank_slot) begin
      r = ROUTE_BANK;
    end else if (shadow_on) begin
      r = ROUTE_SFR;
    end else begin
      r = ROUTE_RAM;
    end
    return r;
  endfunction

endpackage

// File: rtl/swin_decode.sv
module swin_decode #(
  parameter int ADDR_W     = 9,
  parameter int WIN_SIZE   = 16,
  parameter bit WIN_AT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0]           addr,
  output logic                        in_win,
  output logic [$clog2(WIN_SIZE)-1:0] slot,
  output logic                        bank_slot
);
  localparam int SLOT_W = $clog2(WIN_SIZE);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BASE   = WIN_AT_TOP ? (DEPTH - WIN_SIZE) : 0;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SIZE_A = ADDR_W'(WIN_SIZE);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WIN_SIZE - 1);

  logic [ADDR_W-1:0] offset;

  generate
    if (WIN_AT_TOP) begin : g_top
      assign in_win = (addr >= BASE_A);
    end else begin : g_bottom
      assign in_win = (addr < SIZE_A);
    end
  endgenerate

  always_comb begin
    offset    = addr - BASE_A;
    slot      = offset[SLOT_W-1:0];
    bank_slot = in_win && (slot == LAST_SLOT);
  end

endmodule

// File: rtl/swin_ram.sv
module swin_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/swin_sfr_file.sv
module swin_sfr_file #(
  parameter int DATA_W    = 32,
  parameter int WIN_SIZE  = 16,
  parameter int NUM_BANKS = 4,
  localparam int SLOT_W   = $clog2(WIN_SIZE),
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              bank_we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot,
  output logic [DATA_W-1:0] rdata,
  output logic [BANK_W-1:0] bank_q
);
  localparam int REGS_PB = WIN_SIZE - 1;
  localparam int TOTAL   = NUM_BANKS * REGS_PB;
  localparam int IDX_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic [DATA_W-1:0] regs_flat [TOTAL];
  logic [BANK_W-1:0] bank_d;
  logic [IDX_W-1:0]  ridx;

  // Bank selector: next state and register
  always_comb begin
    bank_d = bank_q;
    if (bank_we) begin
      bank_d = wdata[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

  // One register per bank and slot
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar s = 0; s < REGS_PB; s++) begin : g_slot
      logic              hit;
      logic [DATA_W-1:0] q_r;
      logic [DATA_W-1:0] q_d;

      assign hit = reg_we && (bank_q == BANK_W'(b)) && (wslot == SLOT_W'(s));

      always_comb begin
        q_d = q_r;
        if (hit) begin
          q_d = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_d;
        end
      end

      assign regs_flat[b*REGS_PB + s] = q_r;
    end
  end

  always_comb begin
    ridx  = IDX_W'(bank_q) * IDX_W'(REGS_PB) + IDX_W'(rslot);
    rdata = '0;
    if (rslot < SLOT_W'(REGS_PB)) begin
      rdata = regs_flat[ridx];
    end
  end

endmodule

// File: rtl/shadow_window.sv
module shadow_window
  import shadow_win_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 32,
  parameter int WIN_SIZE   = 16,
  parameter int NUM_BANKS  = 4,
  parameter bit WIN_AT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] fetch_data,
  input  logic [ADDR_W-1:0] op_raddr,
  output logic [DATA_W-1:0] op_rdata,
  input  logic              op_we,
  input  logic              op_call,
  input  logic [ADDR_W-1:0] op_waddr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              ctl_we,
  input  logic              ctl_shadow
);
  localparam int SLOT_W = $clog2(WIN_SIZE);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              shadow_q;
  logic              shadow_d;
  logic              rd_in_win;
  logic              rd_bank_slot;
  logic [SLOT_W-1:0] rd_slot;
  logic              wr_in_win;
  logic              wr_bank_slot;
  logic [SLOT_W-1:0] wr_slot;
  route_e            rd_route;
  route_e            wr_route;
  logic              ram_we;
  logic              sfr_we;
  logic              bank_we;
  logic [DATA_W-1:0] ram_op_rdata;
  logic [DATA_W-1:0] sfr_rdata;
  logic [BANK_W-1:0] bank_q;

  // Shadow-enable control bit
  always_comb begin
    shadow_d = shadow_q;
    if (ctl_we) begin
      shadow_d = ctl_shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
    end
  end

  swin_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_SIZE  (WIN_SIZE),
    .WIN_AT_TOP(WIN_AT_TOP)
  ) u_rd_dec (
    .addr     (op_raddr),
    .in_win   (rd_in_win),
    .slot     (rd_slot),
    .bank_slot(rd_bank_slot)
  );

  swin_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_SIZE  (WIN_SIZE),
    .WIN_AT_TOP(WIN_AT_TOP)
  ) u_wr_dec (
    .addr     (op_waddr),
    .in_win   (wr_in_win),
    .slot     (wr_slot),
    .bank_slot(wr_bank_slot)
  );

  always_comb begin
    rd_route = route_access(rd_in_win, rd_bank_slot, shadow_q, 1'b0);
    wr_route = route_access(wr_in_win, wr_bank_slot, shadow_q, op_call);
    ram_we   = op_we && (wr_route == ROUTE_RAM);
    sfr_we   = op_we && (wr_route == ROUTE_SFR);
    bank_we  = op_we && (wr_route == ROUTE_BANK);
  end

  swin_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk    (clk),
    .we     (ram_we),
    .waddr  (op_waddr),
    .wdata  (op_wdata),
    .raddr_a(fetch_addr),
    .rdata_a(fetch_data),
    .raddr_b(op_raddr),
    .rdata_b(ram_op_rdata)
  );

  swin_sfr_file #(
    .DATA_W   (DATA_W),
    .WIN_SIZE (WIN_SIZE),
    .NUM_BANKS(NUM_BANKS)
  ) u_sfr (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_we (sfr_we),
    .bank_we(bank_we),
    .wslot  (wr_slot),
    .wdata  (op_wdata),
    .rslot  (rd_slot),
    .rdata  (sfr_rdata),
    .bank_q (bank_q)
  );

  always_comb begin
    case (rd_route)
      ROUTE_SFR:  op_rdata = sfr_rdata;
      ROUTE_BANK: op_rdata = {{(DATA_W-BANK_W){1'b0}}, bank_q};
      default:    op_rdata = ram_op_rdata;
    endcase
  end

endmodule

// File: rtl/shadow_window_chk.sv
module shadow_window_chk #(
  parameter int DATA_W = 32,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic              ctl_shadow,
  input logic              shadow_q,
  input logic              op_we,
  input logic              op_call,
  input logic [DATA_W-1:0] op_wdata,
  input logic [DATA_W-1:0] op_rdata,
  input logic              wr_in_win,
  input logic              wr_bank_slot,
  input logic              rd_bank_slot,
  input logic              ram_we,
  input logic              sfr_we,
  input logic              bank_we,
  input logic [BANK_W-1:0] bank_q
);

  // R6
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (shadow_q == $past(ctl_shadow)));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(shadow_q));

  // R7
  call_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && op_call) |-> (ram_we && !sfr_we && !bank_we));

  // R3
  sfr_spares_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && !op_call && wr_in_win && !wr_bank_slot && shadow_q) |-> (sfr_we && !ram_we));

  // R2
  plain_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && !op_call && wr_in_win && !wr_bank_slot && !shadow_q) |-> (ram_we && !sfr_we));

  // R5
  outside_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && !wr_in_win) |-> (ram_we && !sfr_we && !bank_we));

  // R8
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_q == $past(op_wdata[BANK_W-1:0])));

  // R8
  bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bank_slot |-> (op_rdata == {{(DATA_W-BANK_W){1'b0}}, bank_q}));

endmodule

bind shadow_window shadow_window_chk #(
  .DATA_W(DATA_W),
  .BANK_W(BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_we      (ctl_we),
  .ctl_shadow  (ctl_shadow),
  .shadow_q    (shadow_q),
  .op_we       (op_we),
  .op_call     (op_call),
  .op_wdata    (op_wdata),
  .op_rdata    (op_rdata),
  .wr_in_win   (wr_in_win),
  .wr_bank_slot(wr_bank_slot),
  .rd_bank_slot(rd_bank_slot),
  .ram_we      (ram_we),
  .sfr_we      (sfr_we),
  .bank_we     (bank_we),
  .bank_q      (bank_q)
);

// File: tb/shadow_window_test.sv
module shadow_window_test;

  logic        clk;
  logic        rst_n;
  logic [8:0]  fetch_addr;
  logic [8:0]  op_raddr;
  logic        op_we;
  logic        op_call;
  logic [8:0]  op_waddr;
  logic [31:0] op_wdata;
  logic        ctl_we;
  logic        ctl_shadow;
  logic [31:0] fd0, fd1, rd0, rd1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] ram_m [2][512];
  logic [31:0] reg_m [2][4][15];
  logic [1:0]  bank_m [2];
  bit          shadow_m;

  // R10: bottom-placed window
  shadow_window #(.WIN_AT_TOP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fd0),
    .op_raddr(op_raddr), .op_rdata(rd0), .op_we(op_we), .op_call(op_call),
    .op_waddr(op_waddr), .op_wdata(op_wdata), .ctl_we(ctl_we), .ctl_shadow(ctl_shadow));

  // R10: top-placed window
  shadow_window #(.WIN_AT_TOP(1'b1)) uut_top (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_data(fd1),
    .op_raddr(op_raddr), .op_rdata(rd1), .op_we(op_we), .op_call(op_call),
    .op_waddr(op_waddr), .op_wdata(op_wdata), .ctl_we(ctl_we), .ctl_shadow(ctl_shadow));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int base_of(int i);
    return (i == 1) ? 496 : 0;
  endfunction

  function automatic bit in_win(int i, int a);
    return (a >= base_of(i)) && (a < base_of(i) + 16);
  endfunction

  function automatic logic [31:0] exp_op(int i, int a);
    int s;
    if (!in_win(i, a)) return ram_m[i][a];
    s = a - base_of(i);
    if (s == 15) return {30'd0, bank_m[i]};
    if (shadow_m) return reg_m[i][bank_m[i]][s];
    return ram_m[i][a];
  endfunction

  function automatic string tag_op(int i, int a);
    string t;
    if (!in_win(i, a))                t = "R5";
    else if (a - base_of(i) == 15)    t = "R8";
    else if (shadow_m)                t = "R3/R9";
    else                              t = "R2";
    if (i == 1 && in_win(i, a)) t = {"R10 ", t};
    return t;
  endfunction

  function automatic logic [31:0] ram_pat(int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(string req, int i, int a, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s inst %0d addr %0d: got %h expected %h", req, i, a, got, exp);
    end
  endtask

  task automatic model_write(int a, logic [31:0] d, bit call);
    for (int i = 0; i < 2; i++) begin
      int s;
      s = a - base_of(i);
      if (call || !in_win(i, a))  ram_m[i][a] = d;
      else if (s == 15)           bank_m[i] = d[1:0];
      else if (shadow_m)          reg_m[i][bank_m[i]][s] = d;
      else                        ram_m[i][a] = d;
    end
  endtask

  // One clock cycle with optional write and optional control write
  task automatic cycle(bit we, int a, logic [31:0] d, bit call, bit cwe, bit cv);
    @(negedge clk);
    op_we      = we;
    op_waddr   = 9'(a);
    op_wdata   = d;
    op_call    = call;
    ctl_we     = cwe;
    ctl_shadow = cv;
    @(posedge clk);
    if (we) model_write(a, d, call);
    if (cwe) shadow_m = cv;
  endtask

  task automatic wr(int a, logic [31:0] d, bit call);
    cycle(1'b1, a, d, call, 1'b0, 1'b0);
  endtask

  task automatic set_shadow(bit v);
    cycle(1'b0, 0, 32'd0, 1'b0, 1'b1, v);
  endtask

  task automatic peek(int a);
    op_raddr   = 9'(a);
    fetch_addr = 9'(a);
    #1;
    check(tag_op(0, a), 0, a, rd0, exp_op(0, a));
    check(tag_op(1, a), 1, a, rd1, exp_op(1, a));
    check("R4", 0, a, fd0, ram_m[0][a]);
    check("R4", 1, a, fd1, ram_m[1][a]);
  endtask

  task automatic sweep();
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      op_we  = 1'b0;
      ctl_we = 1'b0;
      peek(a);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_we = 1'b0; op_call = 1'b0; op_waddr = '0; op_wdata = '0;
    ctl_we = 1'b0; ctl_shadow = 1'b0; op_raddr = '0; fetch_addr = '0;
    shadow_m = 0;
    for (int i = 0; i < 2; i++) begin
      bank_m[i] = 2'd0;
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 15; s++) reg_m[i][b][s] = 32'd0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: fill all RAM with call writes (bank slots included)
    for (int a = 0; a < 512; a++) wr(a, ram_pat(a), 1'b1);

    // R1, R2, R5: reset state, shadow clear
    sweep();
    // R1: exposed registers read zero after reset
    set_shadow(1'b1);
    sweep();

    // R8, R9: load each bank in both copies
    for (int b = 0; b < 4; b++) begin
      wr(15,  32'(b), 1'b0);
      wr(511, 32'(b), 1'b0);
      for (int s = 0; s < 15; s++) begin
        wr(s,       32'hA000_0000 | (32'(b) << 8) | 32'(s), 1'b0);
        wr(496 + s, 32'hB000_0000 | (32'(b) << 8) | 32'(s), 1'b0);
      end
    end
    // R9: each bank selected in turn; R8 upper bits of bank value ignored
    for (int b = 0; b < 4; b++) begin
      wr(15,  32'hFFFF_FFFC | 32'(b), 1'b0);
      wr(511, 32'hFFFF_FFFC | 32'(b), 1'b0);
      sweep();
    end

    // R3: RAM under the window kept its old words
    set_shadow(1'b0);
    sweep();

    // R6: read in the cycle of the control write still sees the old mode
    @(negedge clk);
    op_we = 1'b0; ctl_we = 1'b1; ctl_shadow = 1'b1;
    peek(4);
    peek(500);
    @(posedge clk);
    shadow_m = 1;
    // R6: next cycle sees the new mode
    @(negedge clk);
    ctl_we = 1'b0;
    peek(4);
    peek(500);

    // R6: write in the cycle that clears shadow uses the old (set) mode
    cycle(1'b1, 3,   32'hC0DE_0003, 1'b0, 1'b1, 1'b0);
    cycle(1'b1, 499, 32'hC0DE_01F3, 1'b0, 1'b0, 1'b0);
    sweep();
    // R2: write with shadow clear goes to RAM only
    wr(6,   32'hD00D_0006, 1'b0);
    wr(502, 32'hD00D_01F6, 1'b0);
    set_shadow(1'b1);
    sweep();

    // R7: call writes inside the window while shadowed
    wr(7,   32'hCA11_0007, 1'b1);
    wr(15,  32'hCA11_000F, 1'b1);
    wr(500, 32'hCA11_01F4, 1'b1);
    wr(511, 32'hCA11_01FF, 1'b1);
    sweep();
    set_shadow(1'b0);
    sweep();

    finish_run();
  end

endmodule